// File: doc/BRIEF.md
# Accumulator and Extend-Bit Update Unit

This block works out the next value of a processor's accumulator and of its one-bit extend flag. It serves two kinds of operation. The first kind is the data operations that read a memory operand: AND, add and load. The second kind is twelve register operations, each selected by one bit of a one-hot field taken from the instruction. Along with the new accumulator and extend values, it produces a skip request for the four conditional-skip operations and a halt request for the stop operation.

The surrounding sequencer supplies four things: the current accumulator, the data-register operand, the current extend bit, and the decoded strobes together with an execute enable. All four outputs are registered, so results appear one clock after the strobe is presented. When no strobe is active, or when execute enable is low, the block passes the current accumulator and extend bit through unchanged.

Top module: `acc_ext_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `ac_out`, `e_out`, `skip` and `halt` are all 0 after that edge.
- R2: `reg_op[11]` makes the next `ac_out` 0. `reg_op[10]` makes the next `e_out` 0.
- R3: `reg_op[9]` makes the next `ac_out` the bitwise inverse of `ac_in`. `reg_op[8]` makes the next `e_out` the inverse of `e_in`.
- R4: `reg_op[7]` rotates right through the extend bit. The next `ac_out` is `ac_in` shifted right by one, with `e_in` in the top bit, and the next `e_out` is `ac_in[0]`.
- R5: `reg_op[6]` rotates left through the extend bit. The next `ac_out` is `ac_in` shifted left by one, with `e_in` in bit 0, and the next `e_out` is the old top bit.
- R6: `reg_op[5]` makes the next `ac_out` equal to `ac_in + 1`, wrapping from all ones to zero, and leaves `e_out` equal to `e_in`.
- R7: The conditional skips are as follows. `reg_op[4]` skips when the top bit of `ac_in` is 0, and `reg_op[3]` skips when it is 1. `reg_op[2]` skips when `ac_in` is zero. `reg_op[1]` skips when `e_in` is 0.
- R8: `reg_op[0]` raises `halt` for one cycle and leaves the accumulator and extend bit unchanged.
- R9: `op_and` makes the next `ac_out` equal to `ac_in & dr_in`.
- R10: `op_add` makes the next `ac_out` the low bits of `ac_in + dr_in`, and the next `e_out` the carry-out.
- R11: `op_load` makes the next `ac_out` equal to `dr_in`, with the extend bit unchanged.
- R12: When no strobe is active, or `exec_en` is low, the next `ac_out` equals `ac_in` and the next `e_out` equals `e_in`. At most one strobe is active at a time.
- R13: `skip` and `halt` are single-cycle pulses. Each is high only in the cycle after a cycle in which `exec_en` was high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_en | input | 1 | Execute enable qualifying all strobes |
| op_and | input | 1 | Memory-operand AND strobe |
| op_add | input | 1 | Memory-operand add strobe |
| op_load | input | 1 | Memory-operand load strobe |
| reg_op | input | 12 | One-hot register-operation select, bits 11..0 |
| ac_in | input | DATA_W | Current accumulator |
| dr_in | input | DATA_W | Data-register operand |
| e_in | input | 1 | Current extend bit |
| ac_out | output | DATA_W | Registered next accumulator |
| e_out | output | 1 | Registered next extend bit |
| skip | output | 1 | Registered skip request pulse |
| halt | output | 1 | Registered halt request pulse |

## Verification
The bound assertions check several behaviours on every cycle. They cover the reset values and the pass-through when execute enable is low. They cover the clear, complement and load results, and they check that skip and halt are only ever raised after an enabled cycle. The rotations carry bits across the two ends of the word and through the extend bit, and increment and add carry across the word boundary. These corner cases are shown only by the bench scenarios. So are the true and false outcome of each skip condition and the return of skip to zero on the next idle cycle.

// File: rtl/acc_ext_pkg.sv
`timescale 1ns/1ps
package acc_ext_pkg;
  localparam int unsigned REG_OP_COUNT = 12;
  // bit positions inside the one-hot register-operation field
  localparam int unsigned RB_CLR_AC  = 11;
  localparam int unsigned RB_CLR_E   = 10;
  localparam int unsigned RB_INV_AC  = 9;
  localparam int unsigned RB_INV_E   = 8;
  localparam int unsigned RB_ROT_R   = 7;
  localparam int unsigned RB_ROT_L   = 6;
  localparam int unsigned RB_INC     = 5;
  localparam int unsigned RB_SK_POS  = 4;
  localparam int unsigned RB_SK_NEG  = 3;
  localparam int unsigned RB_SK_ZERO = 2;
  localparam int unsigned RB_SK_E0   = 1;
  localparam int unsigned RB_STOP    = 0;

  typedef struct packed {
    logic do_and;
    logic do_add;
    logic do_load;
  } mem_op_t;
endpackage

// File: rtl/acc_datapath.sv
`timescale 1ns/1ps
module acc_datapath
  import acc_ext_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  mem_op_t                  mem_op,
  input  logic [REG_OP_COUNT-1:0]  reg_op,
  input  logic [DATA_W-1:0]        ac_cur,
  input  logic [DATA_W-1:0]        dr_cur,
  input  logic                     e_cur,
  output logic [DATA_W-1:0]        ac_nxt,
  output logic                     e_nxt
);
  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W:0] sum_w;
  assign sum_w = {1'b0, ac_cur} + {1'b0, dr_cur};

  always_comb begin
    ac_nxt = ac_cur;
    e_nxt  = e_cur;
    if (mem_op.do_and) begin
      ac_nxt = ac_cur & dr_cur;
    end else if (mem_op.do_add) begin
      ac_nxt = sum_w[MSB:0];
      e_nxt  = sum_w[DATA_W];
    end else if (mem_op.do_load) begin
      ac_nxt = dr_cur;
    end else if (reg_op[RB_CLR_AC]) begin
      ac_nxt = '0;
    end else if (reg_op[RB_CLR_E]) begin
      e_nxt = 1'b0;
    end else if (reg_op[RB_INV_AC]) begin
      ac_nxt = ~ac_cur;
    end else if (reg_op[RB_INV_E]) begin
      e_nxt = ~e_cur;
    end else if (reg_op[RB_ROT_R]) begin
      ac_nxt = {e_cur, ac_cur[MSB:1]};
      e_nxt  = ac_cur[0];
    end else if (reg_op[RB_ROT_L]) begin
      ac_nxt = {ac_cur[MSB-1:0], e_cur};
      e_nxt  = ac_cur[MSB];
    end else if (reg_op[RB_INC]) begin
      ac_nxt = ac_cur + {{(DATA_W-1){1'b0}}, 1'b1};
    end
  end
endmodule

// File: rtl/acc_cond_unit.sv
`timescale 1ns/1ps
module acc_cond_unit
  import acc_ext_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic                     exec_en,
  input  logic [REG_OP_COUNT-1:0]  reg_op,
  input  logic [DATA_W-1:0]        ac_cur,
  input  logic                     e_cur,
  output logic                     skip_req,
  output logic                     halt_req
);
  logic sign_b;
  logic ac_zero;
  assign sign_b  = ac_cur[DATA_W-1];
  assign ac_zero = (ac_cur == '0);

  assign skip_req = exec_en & ((reg_op[RB_SK_POS]  & ~sign_b)  |
                               (reg_op[RB_SK_NEG]  &  sign_b)  |
                               (reg_op[RB_SK_ZERO] &  ac_zero) |
                               (reg_op[RB_SK_E0]   & ~e_cur));
  assign halt_req = exec_en & reg_op[RB_STOP];
endmodule

// File: rtl/acc_ext_unit.sv
`timescale 1ns/1ps
module acc_ext_unit
  import acc_ext_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    exec_en,
  input  logic                    op_and,
  input  logic                    op_add,
  input  logic                    op_load,
  input  logic [REG_OP_COUNT-1:0] reg_op,
  input  logic [DATA_W-1:0]       ac_in,
  input  logic [DATA_W-1:0]       dr_in,
  input  logic                    e_in,
  output logic [DATA_W-1:0]       ac_out,
  output logic                    e_out,
  output logic                    skip,
  output logic                    halt
);
  mem_op_t                 mem_q;
  logic [REG_OP_COUNT-1:0] reg_q;
  logic [DATA_W-1:0]       ac_calc;
  logic                    e_calc;
  logic                    skip_calc;
  logic                    halt_calc;

  // strobes only count while execution is enabled
  assign mem_q = '{do_and: op_and & exec_en, do_add: op_add & exec_en, do_load: op_load & exec_en};
  assign reg_q = reg_op & {REG_OP_COUNT{exec_en}};

  acc_datapath #(.DATA_W(DATA_W)) dp_i (
    .mem_op (mem_q),
    .reg_op (reg_q),
    .ac_cur (ac_in),
    .dr_cur (dr_in),
    .e_cur  (e_in),
    .ac_nxt (ac_calc),
    .e_nxt  (e_calc)
  );

  acc_cond_unit #(.DATA_W(DATA_W)) cond_i (
    .exec_en  (exec_en),
    .reg_op   (reg_op),
    .ac_cur   (ac_in),
    .e_cur    (e_in),
    .skip_req (skip_calc),
    .halt_req (halt_calc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ac_out <= '0;
      e_out  <= 1'b0;
      skip   <= 1'b0;
      halt   <= 1'b0;
    end else begin
      ac_out <= ac_calc;
      e_out  <= e_calc;
      skip   <= skip_calc;
      halt   <= halt_calc;
    end
  end
endmodule

// File: rtl/acc_ext_checker.sv
`timescale 1ns/1ps
module acc_ext_checker
  import acc_ext_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    exec_en,
  input logic                    op_and,
  input logic                    op_add,
  input logic                    op_load,
  input logic [REG_OP_COUNT-1:0] reg_op,
  input logic [DATA_W-1:0]       ac_in,
  input logic [DATA_W-1:0]       dr_in,
  input logic                    e_in,
  input logic [DATA_W-1:0]       ac_out,
  input logic                    e_out,
  input logic                    skip,
  input logic                    halt
);
  assert_reset_values_R1: assert property (@(posedge clk)
    rst |=> (ac_out == '0 && !e_out && !skip && !halt));

  assert_clear_ac_R2: assert property (@(posedge clk) disable iff (rst)
    (exec_en && reg_op[RB_CLR_AC]) |=> (ac_out == '0));

  assert_invert_ac_R3: assert property (@(posedge clk) disable iff (rst)
    (exec_en && reg_op[RB_INV_AC]) |=> (ac_out == ~$past(ac_in)));

  assert_load_R11: assert property (@(posedge clk) disable iff (rst)
    (exec_en && op_load) |=> (ac_out == $past(dr_in) && e_out == $past(e_in)));

  assert_and_R9: assert property (@(posedge clk) disable iff (rst)
    (exec_en && op_and) |=> (ac_out == ($past(ac_in) & $past(dr_in))));

  assert_hold_disabled_R12: assert property (@(posedge clk) disable iff (rst)
    !exec_en |=> (ac_out == $past(ac_in) && e_out == $past(e_in)));

  assert_single_strobe_R12: assert property (@(posedge clk) disable iff (rst)
    exec_en |-> $onehot0({op_and, op_add, op_load, reg_op}));

  assert_skip_enabled_R13: assert property (@(posedge clk) disable iff (rst)
    skip |-> $past(exec_en));

  assert_halt_source_R8: assert property (@(posedge clk) disable iff (rst)
    halt |-> $past(exec_en && reg_op[RB_STOP]));
endmodule

bind acc_ext_unit acc_ext_checker #(.DATA_W(DATA_W)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .exec_en (exec_en),
  .op_and  (op_and),
  .op_add  (op_add),
  .op_load (op_load),
  .reg_op  (reg_op),
  .ac_in   (ac_in),
  .dr_in   (dr_in),
  .e_in    (e_in),
  .ac_out  (ac_out),
  .e_out   (e_out),
  .skip    (skip),
  .halt    (halt)
);

// File: tb/acc_ext_unit_tb_top.sv
`timescale 1ns/1ps
module acc_ext_unit_tb_top;
  localparam int unsigned W = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          exec_en = 1'b0;
  logic          op_and = 1'b0;
  logic          op_add = 1'b0;
  logic          op_load = 1'b0;
  logic [11:0]   reg_op = '0;
  logic [W-1:0]  ac_in = '0;
  logic [W-1:0]  dr_in = '0;
  logic          e_in = 1'b0;
  logic [W-1:0]  ac_out;
  logic          e_out;
  logic          skip;
  logic          halt;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  acc_ext_unit #(.DATA_W(W)) dut_i (
    .clk(clk), .rst(rst), .exec_en(exec_en), .op_and(op_and), .op_add(op_add),
    .op_load(op_load), .reg_op(reg_op), .ac_in(ac_in), .dr_in(dr_in), .e_in(e_in),
    .ac_out(ac_out), .e_out(e_out), .skip(skip), .halt(halt)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one cycle of stimulus, then sample just after the capturing edge
  task automatic step(input logic [2:0] mem, input logic [11:0] rop, input logic [W-1:0] ac,
                      input logic [W-1:0] dr, input logic e, input logic en);
    {op_and, op_add, op_load} = mem;
    reg_op  = rop;
    ac_in   = ac;
    dr_in   = dr;
    e_in    = e;
    exec_en = en;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [11:0] rb(input int i);
    return 12'(1) << i;
  endfunction

  task automatic t_reset;
    check("R1 ac", ac_out, '0);
    check("R1 e", W'(e_out), '0);
    check("R1 skip", W'(skip), '0);
    check("R1 halt", W'(halt), '0);
  endtask

  task automatic t_mem_ops;
    step(3'b100, '0, 16'hF0F0, 16'h3C3C, 1'b1, 1'b1);
    check("R9 and", ac_out, 16'h3030);
    step(3'b010, '0, 16'hFFFF, 16'h0001, 1'b0, 1'b1);
    check("R10 add wrap", ac_out, 16'h0000);
    check("R10 carry", W'(e_out), 16'd1);
    step(3'b010, '0, 16'h1234, 16'h0100, 1'b1, 1'b1);
    check("R10 add", ac_out, 16'h1334);
    check("R10 no carry", W'(e_out), 16'd0);
    step(3'b001, '0, 16'h1111, 16'hBEEF, 1'b1, 1'b1);
    check("R11 load", ac_out, 16'hBEEF);
    check("R11 e kept", W'(e_out), 16'd1);
  endtask

  task automatic t_clear_invert;
    step('0, rb(11), 16'hA5A5, 16'h0, 1'b1, 1'b1);
    check("R2 clr ac", ac_out, 16'h0);
    check("R2 e kept", W'(e_out), 16'd1);
    step('0, rb(10), 16'hA5A5, 16'h0, 1'b1, 1'b1);
    check("R2 clr e", W'(e_out), 16'd0);
    check("R2 ac kept", ac_out, 16'hA5A5);
    step('0, rb(9), 16'h00FF, 16'h0, 1'b0, 1'b1);
    check("R3 inv ac", ac_out, 16'hFF00);
    step('0, rb(8), 16'h00FF, 16'h0, 1'b1, 1'b1);
    check("R3 inv e", W'(e_out), 16'd0);
  endtask

  task automatic t_rotate;
    step('0, rb(7), 16'h8001, 16'h0, 1'b0, 1'b1);
    check("R4 rotr ac", ac_out, 16'h4000);
    check("R4 rotr e", W'(e_out), 16'd1);
    step('0, rb(7), 16'h0002, 16'h0, 1'b1, 1'b1);
    check("R4 rotr fill", ac_out, 16'h8001);
    check("R4 rotr e0", W'(e_out), 16'd0);
    step('0, rb(6), 16'h8001, 16'h0, 1'b0, 1'b1);
    check("R5 rotl ac", ac_out, 16'h0002);
    check("R5 rotl e", W'(e_out), 16'd1);
    step('0, rb(6), 16'h4000, 16'h0, 1'b1, 1'b1);
    check("R5 rotl fill", ac_out, 16'h8001);
    check("R5 rotl e0", W'(e_out), 16'd0);
  endtask

  task automatic t_increment;
    step('0, rb(5), 16'hFFFF, 16'h0, 1'b1, 1'b1);
    check("R6 inc wrap", ac_out, 16'h0000);
    check("R6 e kept", W'(e_out), 16'd1);
    step('0, rb(5), 16'h00FF, 16'h0, 1'b0, 1'b1);
    check("R6 inc", ac_out, 16'h0100);
  endtask

  task automatic t_skips;
    step('0, rb(4), 16'h7FFF, 16'h0, 1'b0, 1'b1); check("R7 pos yes", W'(skip), 16'd1);
    step('0, rb(4), 16'h8000, 16'h0, 1'b0, 1'b1); check("R7 pos no",  W'(skip), 16'd0);
    step('0, rb(3), 16'h8000, 16'h0, 1'b0, 1'b1); check("R7 neg yes", W'(skip), 16'd1);
    step('0, rb(3), 16'h0001, 16'h0, 1'b0, 1'b1); check("R7 neg no",  W'(skip), 16'd0);
    step('0, rb(2), 16'h0000, 16'h0, 1'b1, 1'b1); check("R7 zero yes", W'(skip), 16'd1);
    step('0, rb(2), 16'h0100, 16'h0, 1'b1, 1'b1); check("R7 zero no",  W'(skip), 16'd0);
    step('0, rb(1), 16'h1234, 16'h0, 1'b0, 1'b1); check("R7 e0 yes", W'(skip), 16'd1);
    check("R7 ac kept", ac_out, 16'h1234);
    step('0, '0, 16'h1234, 16'h0, 1'b0, 1'b1); check("R13 skip pulse", W'(skip), 16'd0);
    step('0, rb(1), 16'h1234, 16'h0, 1'b1, 1'b1); check("R7 e0 no", W'(skip), 16'd0);
    step('0, rb(4), 16'h0001, 16'h0, 1'b0, 1'b0); check("R13 skip gated", W'(skip), 16'd0);
  endtask

  task automatic t_halt;
    step('0, rb(0), 16'h5555, 16'h0, 1'b1, 1'b1);
    check("R8 halt", W'(halt), 16'd1);
    check("R8 ac kept", ac_out, 16'h5555);
    check("R8 e kept", W'(e_out), 16'd1);
    step('0, '0, 16'h5555, 16'h0, 1'b1, 1'b1);
    check("R13 halt pulse", W'(halt), 16'd0);
    step('0, rb(0), 16'h5555, 16'h0, 1'b1, 1'b0);
    check("R13 halt gated", W'(halt), 16'd0);
  endtask

  task automatic t_hold;
    step('0, '0, 16'h9ABC, 16'hFFFF, 1'b1, 1'b1);
    check("R12 idle ac", ac_out, 16'h9ABC);
    check("R12 idle e", W'(e_out), 16'd1);
    step(3'b010, '0, 16'h8000, 16'h8000, 1'b0, 1'b0);
    check("R12 disabled ac", ac_out, 16'h8000);
    check("R12 disabled e", W'(e_out), 16'd0);
    step('0, rb(11), 16'h0F0F, 16'h0, 1'b1, 1'b0);
    check("R12 disabled clr", ac_out, 16'h0F0F);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst = 1'b0;
    t_mem_ops();
    t_clear_invert();
    t_rotate();
    t_increment();
    t_skips();
    t_halt();
    t_hold();
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end
endmodule